// File: doc/BRIEF.md
# Page-Seeded NAND Data Scrambler

This block sits in the byte datapath of a NAND flash controller. It whitens bytes on their way to the array and restores them on the way back. Both directions use the same operation: each byte is XORed with the low byte of a 15-bit linear feedback shift register, and the register then advances by one byte's worth of steps. The register restarts for every page from a small seed table that is indexed by the page number.

Before a transfer the controller issues a configuration pulse. The pulse carries a page number, a starting column, a layout mode and an enable. The block works out which region of the page the column falls in and picks the page seed or the spare-area sub-seed. It then advances the register one step per clock to the exact column. While it does this it raises `busy_o`. When the register is positioned, bytes flow through a valid/ready stream. `rem_o` counts the bytes left in the current region. Once that count reaches zero the stream stalls until the controller repositions the block with a new configuration pulse.

Top module: `nand_scrambler`

## Requirements
- R1: The state is 15 bits. One step moves the state right by one place, and the new bit 14 is the XOR of the old bits 0 and 1. For page 0 the start state is 0x4A80.
- R2: Each accepted byte leaves as `in_data_i` XOR state[7:0]. The state then advances by 8 steps.
- R3: The seed of a page is entry (page mod N_SEEDS) of the seed table. Entry 0 is 0x4A80, entry 1 is 0x1D3B, entry 2 is 0x2C55 and entry 3 is 0x6F01.
- R4: In mode 0 (flat), the start state is the seed advanced by (column mod 4096) bytes, and `rem_o` is page-plus-spare size minus the column.
- R5: In mode 1 (per-chunk ECC layout), a column below the page data size starts from the seed advanced by (column mod chunk size) bytes, and `rem_o` is the chunk size minus that offset.
- R6: In mode 1, a column in the spare ECC region uses a stride of (ECC bytes + 4). The region spans page size up to page size + chunks × stride. The start state is the sub-seed advanced by ((column − page size) mod stride) bytes, and `rem_o` is the stride minus that offset. The sub-seed is the seed advanced by one chunk length in bytes.
- R7: In mode 2 (interleaved), a span is chunk + prepad + ECC bytes, and the mode applies to columns below chunks × span. For offset o = column mod span, `rem_o` is span − o. The start state is the seed advanced by o bytes when o < chunk size; otherwise it is the sub-seed advanced by (o − chunk size) bytes.
- R8: In modes 1 and 2, a column past the chunked regions follows the flat rule of R4.
- R9: After an enabled configuration pulse, `busy_o` stays high for exactly N+1 cycles, where N is the number of single steps to the start state. No byte is transferred while `busy_o` is high.
- R10: When `rem_o` reaches 0, `in_ready_o` and `out_valid_o` stay low until the next configuration pulse.
- R11: After reset, and after a pulse with the enable low, bytes pass through unchanged, `busy_o` is low and `rem_o` is 0.
- R12: While the block is positioned, `out_valid_o` follows `in_valid_i` and `in_ready_o` follows `out_ready_i`. A byte is consumed only when both are high, and each consumed byte lowers `rem_o` by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start_i | input | 1 | One-cycle pulse that positions the block |
| cfg_page_i | input | PAGE_W | Page number |
| cfg_col_i | input | COL_W | Starting column within page plus spare |
| cfg_mode_i | input | 2 | Layout: 0 flat, 1 per-chunk ECC, 2 interleaved |
| cfg_en_i | input | 1 | Scrambling enable |
| busy_o | output | 1 | Register is being advanced to the column |
| rem_o | output | COL_W | Bytes left in the current region |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted |
| in_data_i | input | 8 | Input byte |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 8 | Output byte |

## Verification
The assertions assume the configured column is below the page-plus-spare size. They also assume no configuration pulse arrives while the stream is expected to move a byte. The stimulus keeps every column inside the page, and it drives the pulse only in cycles where no byte is offered. The bench model computes region, offset and seed position with plain integer arithmetic. It checks every moving byte while `out_ready_i` toggles, so that stalls and consumption are both exercised.

// File: rtl/nscr_pkg.sv
package nscr_pkg;
  typedef logic [14:0] lfsr_t;

  typedef enum logic [1:0] {
    MODE_FLAT  = 2'd0,
    MODE_CHUNK = 2'd1,
    MODE_ILV   = 2'd2,
    MODE_RSVD  = 2'd3
  } layout_e;

  function automatic lfsr_t lfsr_step(input lfsr_t s);
    return {s[0] ^ s[1], s[14:1]};
  endfunction

  function automatic lfsr_t lfsr_byte(input lfsr_t s);
    lfsr_t t;
    t = s;
    for (int i = 0; i < 8; i++) t = lfsr_step(t);
    return t;
  endfunction
endpackage

// File: rtl/nscr_locator.sv
module nscr_locator #(
  parameter int PAGE_BYTES   = 512,
  parameter int SPARE_BYTES  = 80,
  parameter int CHUNK_BYTES  = 128,
  parameter int ECC_BYTES    = 12,
  parameter int PREPAD_BYTES = 4,
  parameter int COL_W        = 10,
  parameter int OFF_W        = 12
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [1:0]       mode_i,
  output logic             sub_o,
  output logic [OFF_W-1:0] off_o,
  output logic [COL_W-1:0] left_o
);
  import nscr_pkg::*;

  localparam int TOTAL   = PAGE_BYTES + SPARE_BYTES;
  localparam int NCH     = PAGE_BYTES / CHUNK_BYTES;
  localparam int STRIDE  = ECC_BYTES + 4;
  localparam int SPAN    = CHUNK_BYTES + PREPAD_BYTES + ECC_BYTES;
  localparam int ECC_END = PAGE_BYTES + NCH * STRIDE;
  localparam int IL_END  = NCH * SPAN;

  int c_v, o_v, l_v;
  logic s_v;

  always_comb begin
    c_v = int'(col_i);
    s_v = 1'b0;
    o_v = c_v % 4096;
    l_v = TOTAL - c_v;
    case (layout_e'(mode_i))
      MODE_CHUNK: begin
        if (c_v < PAGE_BYTES) begin
          o_v = c_v % CHUNK_BYTES;
          l_v = CHUNK_BYTES - o_v;
        end else if (c_v < ECC_END) begin
          o_v = (c_v - PAGE_BYTES) % STRIDE;
          l_v = STRIDE - o_v;
          s_v = 1'b1;
        end
      end
      MODE_ILV: begin
        if (c_v < IL_END) begin
          o_v = c_v % SPAN;
          l_v = SPAN - o_v;
          if (o_v >= CHUNK_BYTES) begin
            o_v = o_v - CHUNK_BYTES;
            s_v = 1'b1;
          end
        end
      end
      default: ;
    endcase
    sub_o  = s_v;
    off_o  = OFF_W'(o_v);
    left_o = COL_W'(l_v);
  end
endmodule

// File: rtl/nscr_lfsr.sv
module nscr_lfsr (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  nscr_pkg::lfsr_t   load_val_i,
  input  logic              step1_i,
  input  logic              step8_i,
  output nscr_pkg::lfsr_t   state_o
);
  import nscr_pkg::*;

  lfsr_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (load_i)       state_d = load_val_i;
    else if (step8_i) state_d = lfsr_byte(state_q);
    else if (step1_i) state_d = lfsr_step(state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R2
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step1_i && !step8_i) |=> $stable(state_q));

  // R1
  lfsr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step1_i && !load_i && !step8_i) |=> (state_q[13:0] == $past(state_q[14:1])));
endmodule

// File: rtl/nand_scrambler.sv
module nand_scrambler #(
  parameter int PAGE_BYTES   = 512,
  parameter int SPARE_BYTES  = 80,
  parameter int CHUNK_BYTES  = 128,
  parameter int ECC_BYTES    = 12,
  parameter int PREPAD_BYTES = 4,
  parameter int PAGE_W       = 16,
  parameter int N_SEEDS      = 4,
  parameter logic [N_SEEDS-1:0][14:0] SEED_TAB =
    {15'h6F01, 15'h2C55, 15'h1D3B, 15'h4A80},
  localparam int TOTAL = PAGE_BYTES + SPARE_BYTES,
  localparam int COL_W = $clog2(TOTAL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start_i,
  input  logic [PAGE_W-1:0] cfg_page_i,
  input  logic [COL_W-1:0]  cfg_col_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic              cfg_en_i,
  output logic              busy_o,
  output logic [COL_W-1:0]  rem_o,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [7:0]        in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [7:0]        out_data_o
);
  import nscr_pkg::*;

  localparam int OFF_W  = 12;
  localparam int STEP_W = $clog2((CHUNK_BYTES + 4096) * 8 + 1);

  typedef enum logic [1:0] {ST_BYPASS, ST_SEEK, ST_RUN} st_e;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic             loc_sub;
  logic [OFF_W-1:0] loc_off;
  logic [COL_W-1:0] loc_left;

  nscr_locator #(
    .PAGE_BYTES(PAGE_BYTES), .SPARE_BYTES(SPARE_BYTES),
    .CHUNK_BYTES(CHUNK_BYTES), .ECC_BYTES(ECC_BYTES),
    .PREPAD_BYTES(PREPAD_BYTES), .COL_W(COL_W), .OFF_W(OFF_W)
  ) i_loc (
    .col_i(cfg_col_i), .mode_i(cfg_mode_i),
    .sub_o(loc_sub), .off_o(loc_off), .left_o(loc_left)
  );

  lfsr_t page_seed;
  int    seed_idx;
  always_comb begin
    seed_idx  = int'(cfg_page_i % PAGE_W'(N_SEEDS));
    page_seed = SEED_TAB[0];
    for (int i = 0; i < N_SEEDS; i++)
      if (i == seed_idx) page_seed = SEED_TAB[i];
  end

  logic [STEP_W-1:0] seek_total;
  assign seek_total = STEP_W'(((loc_sub ? CHUNK_BYTES : 0) + int'(loc_off)) * 8);

  st_e               st_q, st_d;
  logic [STEP_W-1:0] steps_q, steps_d;
  logic [COL_W-1:0]  rem_q, rem_d;
  logic              ld, st1, st8;
  lfsr_t             lfsr_state;

  logic run_ok, fire;
  assign run_ok = (st_q == ST_RUN) && (rem_q != '0) && !cfg_start_i;
  assign fire   = run_ok && in_valid_i && out_ready_i;

  always_comb begin
    st_d    = st_q;
    steps_d = steps_q;
    rem_d   = rem_q;
    ld      = 1'b0;
    st1     = 1'b0;
    st8     = 1'b0;
    if (cfg_start_i) begin
      if (cfg_en_i) begin
        st_d    = ST_SEEK;
        steps_d = seek_total;
        rem_d   = loc_left;
        ld      = 1'b1;
      end else begin
        st_d  = ST_BYPASS;
        rem_d = '0;
      end
    end else begin
      case (st_q)
        ST_SEEK: begin
          if (steps_q == '0) st_d = ST_RUN;
          else begin
            steps_d = steps_q - 1'b1;
            st1     = 1'b1;
          end
        end
        ST_RUN: begin
          if (fire) begin
            rem_d = rem_q - 1'b1;
            st8   = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q    <= ST_BYPASS;
      steps_q <= '0;
      rem_q   <= '0;
    end else begin
      st_q    <= st_d;
      steps_q <= steps_d;
      rem_q   <= rem_d;
    end
  end

  nscr_lfsr i_lfsr (
    .clk(clk), .rst_n(rst_sync_n), .load_i(ld), .load_val_i(page_seed),
    .step1_i(st1), .step8_i(st8), .state_o(lfsr_state)
  );

  always_comb begin
    if (st_q == ST_BYPASS) begin
      out_valid_o = in_valid_i;
      in_ready_o  = out_ready_i;
      out_data_o  = in_data_i;
    end else begin
      out_valid_o = run_ok && in_valid_i;
      in_ready_o  = run_ok && out_ready_i;
      out_data_o  = in_data_i ^ lfsr_state[7:0];
    end
  end

  assign busy_o = (st_q == ST_SEEK);
  assign rem_o  = rem_q;

  // R9
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_o |-> (!out_valid_o && !in_ready_o));

  // R9
  seek_count_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_o && steps_q != '0 && !cfg_start_i) |=> (steps_q == $past(steps_q) - 1'b1));

  // R12
  rem_dec_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fire && !cfg_start_i) |=> (rem_q == $past(rem_q) - 1'b1));

  // R10
  no_fire_exhausted_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == ST_RUN && rem_q == '0) |-> (!out_valid_o && !in_ready_o));

  // R4
  left_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_start_i && cfg_en_i && int'(cfg_col_i) < TOTAL) |=> (rem_q != '0));
endmodule

// File: tb/test_nand_scrambler.sv
module test_nand_scrambler;
  localparam int PAGE = 512, SPARE = 80, CHUNK = 128, ECCB = 12, PREPAD = 4;
  localparam int TOTAL = PAGE + SPARE;
  localparam int COL_W = $clog2(TOTAL + 1);
  localparam int NCH = PAGE / CHUNK;
  localparam int STRIDE = ECCB + 4;
  localparam int SPAN = CHUNK + PREPAD + ECCB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_start_i = 1'b0;
  logic [15:0] cfg_page_i = '0;
  logic [COL_W-1:0] cfg_col_i = '0;
  logic [1:0] cfg_mode_i = '0;
  logic cfg_en_i = 1'b0;
  logic busy_o;
  logic [COL_W-1:0] rem_o;
  logic in_valid_i = 1'b0;
  logic in_ready_o;
  logic [7:0] in_data_i = '0;
  logic out_valid_o;
  logic out_ready_i = 1'b0;
  logic [7:0] out_data_o;

  int checks = 0, failures = 0, cycles = 0;
  int m_state, m_rem;

  always #5 clk = ~clk;

  nand_scrambler i_nand_scrambler (.*);

  function automatic int step(input int s);
    return ((s >> 1) | ((((s) ^ (s >> 1)) & 1) << 14)) & 32'h7fff;
  endfunction

  function automatic int adv(input int s, input int n);
    int t = s;
    for (int i = 0; i < n; i++) t = step(t);
    return t;
  endfunction

  function automatic int seed_of(input int page);
    int tab[4] = '{32'h4A80, 32'h1D3B, 32'h2C55, 32'h6F01};
    return tab[page % 4];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected start state, single-step count and region length
  task automatic locate(input int page, input int col, input int mode,
                        output int st, output int nsteps, output int left);
    bit sub = 0;
    int off = col % 4096;
    left = TOTAL - col;
    if (mode == 1 && col < PAGE) begin
      off = col % CHUNK; left = CHUNK - off;
    end else if (mode == 1 && col < PAGE + NCH * STRIDE) begin
      off = (col - PAGE) % STRIDE; left = STRIDE - off; sub = 1;
    end else if (mode == 2 && col < NCH * SPAN) begin
      off = col % SPAN; left = SPAN - off;
      if (off >= CHUNK) begin off -= CHUNK; sub = 1; end
    end
    nsteps = (sub ? CHUNK * 8 : 0) + off * 8;
    st = adv(seed_of(page), nsteps);
  endtask

  task automatic configure(input int page, input int col, input int mode, input string req);
    int st, ns, lf, n;
    locate(page, col, mode, st, ns, lf);
    @(negedge clk);
    in_valid_i = 0;
    cfg_start_i = 1; cfg_page_i = 16'(page); cfg_col_i = COL_W'(col);
    cfg_mode_i = 2'(mode); cfg_en_i = 1;
    @(negedge clk);
    cfg_start_i = 0;
    n = 0;
    while (busy_o) begin
      in_valid_i = 1; out_ready_i = 1;
      #1;
      if (out_valid_o || in_ready_o) check(0, "R9 moved while busy", 1, 0);
      n++;
      @(negedge clk);
    end
    check(n == ns + 1, {req, "/R9 busy length"}, n, ns + 1);
    check(int'(rem_o) == lf, {req, " remaining"}, rem_o, lf);
    m_state = st; m_rem = lf;
  endtask

  // stream nbytes while out_ready toggles; model compared every clock
  task automatic stream(input int nbytes, input string req);
    int got = 0, k = 0;
    while (got < nbytes) begin
      in_valid_i = 1;
      in_data_i = 8'($urandom);
      out_ready_i = (k % 3) != 2;
      k++;
      #1;
      check(out_valid_o == (m_rem != 0) && in_ready_o == (out_ready_i && m_rem != 0),
            "R12 handshake", {out_valid_o, in_ready_o}, {(m_rem != 0), out_ready_i});
      if (out_valid_o && out_ready_i) begin
        check(out_data_o == (in_data_i ^ 8'(m_state)), {req, "/R2 data"},
              out_data_o, in_data_i ^ 8'(m_state));
        m_state = adv(m_state, 8); m_rem--; got++;
      end
      @(negedge clk);
      if (out_ready_i && m_rem >= 0)
        check(int'(rem_o) == m_rem, "R12 remaining count", rem_o, m_rem);
    end
    in_valid_i = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R11 reset state is pass-through
    in_valid_i = 1; out_ready_i = 1; in_data_i = 8'h5A;
    #1;
    check(!busy_o && rem_o == 0, "R11 reset idle", {busy_o, rem_o}, 0);
    check(out_valid_o && out_data_o == 8'h5A, "R11 reset passthrough", out_data_o, 8'h5A);
    @(negedge clk); in_valid_i = 0;

    // R1 page 0 flat column 0 starts from 0x4A80
    configure(0, 0, 0, "R4");
    check(m_state == 32'h4A80, "R1 default seed", m_state, 32'h4A80);
    stream(20, "R1");
    // reposition continues the same sequence (R4)
    configure(0, 20, 0, "R4 reposition");
    stream(6, "R4");
    // R3 seed table by page
    configure(5, 100, 0, "R3");
    stream(8, "R3");
    configure(7, 3, 0, "R3");
    stream(5, "R3");
    // R5 chunk data area
    configure(2, 130, 1, "R5");
    stream(10, "R5");
    // R6 spare ECC region, run to exhaustion then R10
    configure(1, PAGE + STRIDE + 3, 1, "R6");
    stream(13, "R6");
    in_valid_i = 1; out_ready_i = 1;
    #1;
    check(!in_ready_o && !out_valid_o && rem_o == 0, "R10 stall at zero",
          {in_ready_o, out_valid_o, rem_o}, 0);
    @(negedge clk);
    #1;
    check(!in_ready_o && !out_valid_o, "R10 still stalled", {in_ready_o, out_valid_o}, 0);
    in_valid_i = 0;
    // R8 chunk mode past ECC region
    configure(3, 580, 1, "R8");
    stream(12, "R8");
    // R7 interleaved sub-seed and data parts
    configure(6, SPAN + 130, 2, "R7");
    stream(14, "R7");
    configure(4, 300, 2, "R7");
    stream(9, "R7");
    // R8 interleaved tail
    configure(0, 585, 2, "R8");
    stream(7, "R8");

    // R11 disable gives pass-through
    @(negedge clk);
    cfg_start_i = 1; cfg_en_i = 0; cfg_col_i = COL_W'(40);
    @(negedge clk);
    cfg_start_i = 0;
    for (int i = 0; i < 4; i++) begin
      in_valid_i = 1; out_ready_i = 1; in_data_i = 8'(8'h31 + i);
      #1;
      check(!busy_o && rem_o == 0, "R11 disabled idle", {busy_o, rem_o}, 0);
      check(out_valid_o && out_data_o == 8'(8'h31 + i), "R11 disabled passthrough",
            out_data_o, 8'h31 + i);
      @(negedge clk);
    end
    in_valid_i = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule